// File: doc/BRIEF.md
# Mini UART Register Front End

This block is the register-facing half of a small UART. A simple 32-bit register bus (address, write strobe, write data, read strobe, combinational read data) reaches a handful of registers. Received bytes arrive on a valid/ready byte stream and are stored in a circular receive FIFO. Bytes written to the data register leave at once on a transmit byte stream, so the transmitter is always reported as idle and drained. One level-sensitive interrupt line combines a receive cause and a transmit cause.

Back-pressure rules: a receive byte is taken on a clock edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is low while the FIFO holds `DEPTH` bytes, and also during a cycle in which a FIFO flush is written. The transmit stream has no ready input. `tx_valid` is high for exactly the cycle of the data-register write, and the consumer must take the byte in that cycle. A bus read has its effect (a FIFO pop) at the clock edge that ends the read cycle. `bus_rdata` reflects the state before that edge.

Top module: `mini_uart_regs`

## Requirements
- R1: After reset the FIFO is empty, both interrupt enables are clear, `irq` is low and `rx_ready` is high.
- R2: A receive byte is accepted on a clock edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is low when the FIFO holds `DEPTH` bytes, and a byte offered then is not stored.
- R3: A read at offset 0x40 returns the oldest stored byte in bits 7:0, with zeros above, and removes it. Bytes come out in arrival order across pointer wraparound. A read of an empty FIFO returns the entry at the current read position and changes no state.
- R4: A write at offset 0x40 raises `tx_valid` in that same cycle, with `tx_data` equal to write-data bits 7:0.
- R5: At offset 0x44, bit 0 is the receive-interrupt enable and bit 1 is the transmit-interrupt enable. A write keeps only those two bits, and a read returns 0xC0 ORed with them.
- R6: `irq` is high when the receive enable is set and the FIFO is non-empty, or when the transmit enable is set. It follows the stored state in the same cycle that the state changes.
- R7: A read at offset 0x48 returns 0xC0 ORed with a source code and a pending flag. The source code is 0x4 when the FIFO is non-empty and 0x2 otherwise. Bit 0 is set when `irq` is low.
- R8: A write at offset 0x48 with bit 1 set empties the FIFO. A write there with bit 1 clear leaves the FIFO unchanged.
- R9: A read at offset 0x54 returns 0x60, with bit 0 set when the FIFO is non-empty.
- R10: A read at offset 0x64 returns 0x30E, with bit 0 set when the FIFO is non-empty and the FIFO fill count placed at bit 16 and above.
- R11: A read at 0x00 returns `irq` in bit 0. A read at 0x04 returns 1 and writes there have no effect. A read at 0x60 returns 0x3.
- R12: Offsets 0x4C, 0x50, 0x58, 0x5C, 0x68 and all other unlisted offsets read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (pops on a data-register read) |
| bus_rdata | output | 32 | Combinational read data |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive FIFO can take a byte |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | Transmit byte valid (one cycle per write) |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with `DEPTH` set to 4 rather than the default of 8. With that depth, filling the FIFO to the stall point takes only a few stream beats, and so does wrapping the read pointer past the last slot. Both the back-pressure boundary and the fill-count field of the extended status word are checked at the full value. The stale-entry read of an empty FIFO is reached right after a wrap, where the slot under the read pointer holds a known old byte.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int OFF_IRQ_STAT = 'h00;
  localparam int OFF_ENABLES  = 'h04;
  localparam int OFF_DATA     = 'h40;
  localparam int OFF_IER      = 'h44;
  localparam int OFF_IID      = 'h48;
  localparam int OFF_LSTAT    = 'h54;
  localparam int OFF_CTRL     = 'h60;
  localparam int OFF_XSTAT    = 'h64;

  localparam logic [31:0] IER_RD_BASE = 32'h0000_00C0;
  localparam logic [31:0] IID_RD_BASE = 32'h0000_00C0;
  localparam logic [31:0] LSTAT_BASE  = 32'h0000_0060;
  localparam logic [31:0] XSTAT_BASE  = 32'h0000_030E;
  localparam logic [31:0] CTRL_VALUE  = 32'h0000_0003;

  typedef struct packed {
    logic tx_en;
    logic rx_en;
  } ier_t;
endpackage

// File: rtl/mu_rx_fifo.sv
module mu_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [7:0]       head_data,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W:0]   DEPTH_S  = (CNT_W + 1)'(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   slot_sum;
  logic [PTR_W-1:0] wr_idx;
  logic             do_pop;

  assign slot_sum  = (CNT_W + 1)'(rd_ptr) + (CNT_W + 1)'(cnt);
  assign wr_idx    = (slot_sum >= DEPTH_S) ? PTR_W'(slot_sum - DEPTH_S) : PTR_W'(slot_sum);
  assign do_pop    = pop && (cnt != '0);
  assign head_data = mem[rd_ptr];
  assign count     = cnt;
  assign full      = (cnt == DEPTH_C);

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_pop) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      if (flush)               cnt <= '0;
      else if (push && !do_pop) cnt <= cnt + 1'b1;
      else if (!push && do_pop) cnt <= cnt - 1'b1;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH_C);
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && cnt == '0) |=> ($stable(rd_ptr) && cnt == '0));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == '0);
endmodule

// File: rtl/mu_irq_ctrl.sv
module mu_irq_ctrl
  import mu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_we,
  input  logic [1:0] ier_wdata,
  input  logic       has_data,
  output ier_t       ier,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ier <= '0;
    else if (ier_we) ier <= ier_t'(ier_wdata);
  end

  assign irq = (ier.rx_en && has_data) || ier.tx_en;

  assert_ier_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ier_we |=> ier == ier_t'($past(ier_wdata)));
  assert_ier_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_we |=> $stable(ier));
endmodule

// File: rtl/mu_reg_read.sv
module mu_reg_read
  import mu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  input  logic [7:0]        head_data,
  input  ier_t              ier,
  input  logic              irq,
  output logic [31:0]       rdata
);
  logic has_data;
  assign has_data = (count != '0);

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFF_IRQ_STAT): rdata = {31'd0, irq};
      ADDR_W'(OFF_ENABLES):  rdata = 32'd1;
      ADDR_W'(OFF_DATA):     rdata = {24'd0, head_data};
      ADDR_W'(OFF_IER):      rdata = IER_RD_BASE | {30'd0, ier};
      ADDR_W'(OFF_IID):      rdata = IID_RD_BASE | {29'd0, has_data, !has_data, !irq};
      ADDR_W'(OFF_LSTAT):    rdata = LSTAT_BASE | {31'd0, has_data};
      ADDR_W'(OFF_CTRL):     rdata = CTRL_VALUE;
      ADDR_W'(OFF_XSTAT):    rdata = XSTAT_BASE | {31'd0, has_data} | (32'(count) << 16);
      default:               rdata = '0;
    endcase
  end
endmodule

// File: rtl/mini_uart_regs.sv
module mini_uart_regs
  import mu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             sel_data, sel_ier, sel_iid;
  logic             flush, push, pop, full;
  logic [7:0]       head_data;
  logic [CNT_W-1:0] count;
  ier_t             ier;

  assign sel_data = (bus_addr == ADDR_W'(OFF_DATA));
  assign sel_ier  = (bus_addr == ADDR_W'(OFF_IER));
  assign sel_iid  = (bus_addr == ADDR_W'(OFF_IID));

  assign flush    = bus_wr && sel_iid && bus_wdata[1];
  assign rx_ready = !full && !flush;
  assign push     = rx_valid && rx_ready;
  assign pop      = bus_rd && sel_data;

  assign tx_valid = bus_wr && sel_data;
  assign tx_data  = bus_wdata[7:0];

  mu_rx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (rx_data),
    .pop       (pop),
    .flush     (flush),
    .head_data (head_data),
    .count     (count),
    .full      (full)
  );

  mu_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier_we    (bus_wr && sel_ier),
    .ier_wdata (bus_wdata[1:0]),
    .has_data  (count != '0),
    .ier       (ier),
    .irq       (irq)
  );

  mu_reg_read #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_read (
    .addr      (bus_addr),
    .count     (count),
    .head_data (head_data),
    .ier       (ier),
    .irq       (irq),
    .rdata     (bus_rdata)
  );

  assert_rx_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ier.rx_en && count != '0) |-> irq);
  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier.rx_en && !ier.tx_en) |-> !irq);
  assert_stall_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !rx_ready);
endmodule

// File: tb/sim_mini_uart_regs.sv
module sim_mini_uart_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic [31:0]       bus_rdata;
  logic              rx_valid = 1'b0;
  logic              rx_ready;
  logic [7:0]        rx_data = '0;
  logic              tx_valid;
  logic [7:0]        tx_data;
  logic              irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mini_uart_regs #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input int addr, output logic [31:0] data);
    @(negedge clk);
    bus_addr = ADDR_W'(addr); bus_rd = 1'b1;
    #1 data = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic bus_write(input int addr, input logic [31:0] data,
                           output logic tv, output logic [7:0] td);
    @(negedge clk);
    bus_addr = ADDR_W'(addr); bus_wdata = data; bus_wr = 1'b1;
    #1 begin tv = tx_valid; td = tx_data; end
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    logic tv; logic [7:0] td;
    bus_write(addr, data, tv, td);
  endtask

  // driver: offers a byte, records it in the scoreboard if accepted
  task automatic send_byte(input logic [7:0] b, output logic took);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1 took = rx_ready;
    @(posedge clk); #1 rx_valid = 1'b0;
    if (took) exp_q.push_back(b);
  endtask

  // monitor: pops one byte from the design and compares it
  task automatic take_byte(input string req);
    logic [31:0] d;
    logic [7:0] e;
    bus_read('h40, d);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
    check(req, d, {24'd0, e});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic took, tv;
    logic [7:0] td;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 rx_ready", {31'd0, rx_ready}, 1);
    bus_read('h44, d); check("R1 ier", d, 32'hC0);
    bus_read('h64, d); check("R1 xstat", d, 32'h30E);
    bus_read('h48, d); check("R7 iid empty no irq", d, 32'hC3);

    // three bytes in
    send_byte(8'h11, took); send_byte(8'h22, took); send_byte(8'h33, took);
    bus_read('h64, d); check("R10 xstat 3", d, 32'h0003_030F);
    bus_read('h54, d); check("R9 lstat data", d, 32'h61);
    bus_read('h48, d); check("R7 iid data no irq", d, 32'hC5);
    check("R6 irq off w/o enable", {31'd0, irq}, 0);

    // R5 only two bits kept
    wr('h44, 32'hFFFF_FFFD);
    bus_read('h44, d); check("R5 ier mask", d, 32'hC1);
    @(negedge clk); check("R6 rx irq", {31'd0, irq}, 1);
    bus_read('h48, d); check("R7 iid rx pending", d, 32'hC4);
    bus_read('h00, d); check("R11 irq stat", d, 1);

    // R3 order
    take_byte("R3 order 1"); take_byte("R3 order 2"); take_byte("R3 order 3");
    @(negedge clk); check("R6 irq drops empty", {31'd0, irq}, 0);

    // wrap, then stale read of empty FIFO
    send_byte(8'h44, took); take_byte("R3 slot3");
    bus_read('h40, d); check("R3 empty read stale", d, 32'h11);
    bus_read('h64, d); check("R3 empty read no change", d, 32'h30E);

    // fill to stall (R2)
    send_byte(8'hA1, took); send_byte(8'hA2, took);
    send_byte(8'hA3, took); send_byte(8'hA4, took);
    check("R2 accepted 4th", {31'd0, took}, 1);
    @(negedge clk); check("R2 ready low full", {31'd0, rx_ready}, 0);
    send_byte(8'hEE, took);
    check("R2 refused when full", {31'd0, took}, 0);
    bus_read('h64, d); check("R10 xstat full", d, 32'h0004_030F);
    for (int i = 0; i < DEPTH; i++) take_byte("R3 wrap order");

    // R8 flush
    send_byte(8'h55, took); send_byte(8'h66, took);
    wr('h48, 32'h4);
    bus_read('h64, d); check("R8 no flush bit1 clear", d, 32'h0002_030F);
    wr('h48, 32'h2);
    exp_q.delete();
    bus_read('h54, d); check("R8 flushed lstat", d, 32'h60);
    bus_read('h64, d); check("R8 flushed xstat", d, 32'h30E);

    // R4 transmit
    bus_write('h40, 32'h0000_01A5, tv, td);
    check("R4 tx_valid", {31'd0, tv}, 1);
    check("R4 tx_data", {24'd0, td}, 32'hA5);
    @(negedge clk); check("R4 tx_valid idle", {31'd0, tx_valid}, 0);

    // R6 tx interrupt, R7 source with no data
    wr('h44, 32'h2);
    @(negedge clk); check("R6 tx irq", {31'd0, irq}, 1);
    bus_read('h48, d); check("R7 iid tx pending", d, 32'hC2);

    // R11 fixed registers
    wr('h04, 32'h0);
    bus_read('h04, d); check("R11 enables", d, 1);
    bus_read('h60, d); check("R11 ctrl", d, 3);

    // R12 unimplemented
    wr('h4C, 32'hFF); bus_read('h4C, d); check("R12 lcr", d, 0);
    wr('h50, 32'h3); bus_read('h50, d); check("R12 mcr", d, 0);
    bus_read('h44, d); check("R12 ier untouched", d, 32'hC2);
    bus_read('h58, d); check("R12 msr", d, 0);
    bus_read('h5C, d); check("R12 scratch", d, 0);
    bus_read('h68, d); check("R12 baud", d, 0);
    bus_read('h80, d); check("R12 other", d, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule